// File: doc/BRIEF.md
# Buffered Reload Down-Counter Timer Bank

This block holds five independent down-counting timer channels behind one small register port. Each channel has a count buffer and a compare buffer that software fills first. The live counter takes those values only at two moments: when software holds the channel's manual-load bit, or when the channel expires in auto-reload mode. A channel counts one step on each cycle where its tick-enable input is high and its start bit is set. It expires on the tick that finds the counter at zero. After expiry it either reloads and keeps running, or it stops, which gives a one-shot.

A shared control word holds four bits per channel. A shared interrupt status word holds one enable and one write-one-to-clear pending flag per channel. The interrupt output is raised while any enabled flag is pending. Software reads each channel's live count through its own observation address. Because the counter runs downward, elapsed time is the inverted reading. A period of N ticks needs N−1 in the count buffer. The compare buffer loads alongside the counter and only feeds an internal equality flag, so the last channel has no compare buffer: its compare address carries that channel's live count instead.

Top module: `dtimer_bank`

## Requirements
- R1: After reset, the control word, the status word, every counter and every buffer read as zero, and `irqOut` is low.
- R2: Control word (address 0x08) layout: channel 0 uses bits 3:0 and channel n≥1 uses bits 4(n+1)+3 : 4(n+1). Inside each group, bit 0 is start, bit 1 is manual load, bit 2 is output invert (stored only) and bit 3 is auto-reload. Bits 7:4 and 31:24 always read zero.
- R3: Count buffer n is at byte address 0x0C+12n and compare buffer n (n=0..3) is at 0x10+12n, both read/write. Live count n (n=0..3) is read-only at 0x14+12n. Channel 4 has no compare buffer, and 0x40 reads its live count. Writes to live-count addresses change nothing.
- R4: While a channel's manual-load bit is set, its counter and compare register copy their buffers on every clock, and ticks do not decrement the counter.
- R5: With start set and manual load clear, each cycle with the channel's tick high lowers a nonzero counter by one. With start clear, ticks are ignored and the counter keeps its value, with no reload.
- R6: A tick that finds the counter at zero is an expiry. With auto-reload set, the counter then takes the count-buffer value, so a buffer value B gives a period of B+1 ticks.
- R7: On an expiry with auto-reload clear, the counter stays at zero and the hardware clears that channel's start bit. Later ticks cause no further expiry.
- R8: Status word (address 0x44): bit n is the interrupt enable of channel n and bit n+5 is its pending flag. An expiry sets the pending flag only if the enable was 1. Writing 1 to a pending bit clears it, and writing 0 leaves it. A set on the same clock as a clear wins.
- R9: `irqOut` is high exactly when some channel has both its enable and its pending flag set. Clearing the enable drops the request but keeps the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for `regAddr`/`wrData` |
| regAddr | input | 8 | Byte address of the register accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the register at `regAddr` (combinational) |
| tickEn | input | 5 | Per-channel count enable, bit n for channel n |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bound checker watches every cycle for the counting rules: manual load copying the buffers and matching the compare register, single-step decrement, freezing while stopped, reload on expiry, the one-shot clearing its own start bit, and pending flags that appear only under an enable. The register map is another matter. Bit positions in the control word, address decoding, and the absence of a compare buffer on the last channel only show up through the bench's writes and reads. So do whole-period arithmetic over many ticks and the order of software steps around manual load.

// File: rtl/dtimer_pkg.sv
`timescale 1ns/1ps
package dtimer_pkg;
  localparam int NUM_CH = 5;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PEND_OFS = NUM_CH;

  localparam int BIT_RUN = 0;
  localparam int BIT_MAN = 1;
  localparam int BIT_INV = 2;
  localparam int BIT_AUTO = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h08;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_LIVE_LAST = 8'h40;

  typedef struct packed {
    logic run;
    logic manual;
    logic autoReload;
    logic wrCnt;
    logic wrCmp;
  } chanCmd_t;

  // first control bit of a channel's group; group of channel 1 skips a nibble
  function automatic int ctrlBase(input int ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  function automatic logic [DATA_W-1:0] ctrlMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) m[ctrlBase(c) +: 4] = 4'hF;
    return m;
  endfunction

  function automatic bit hasCmp(input int ch);
    return ch < NUM_CH - 1;
  endfunction

  function automatic logic [ADDR_W-1:0] cntAddr(input int ch);
    return ADDR_W'(12 + 12 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] cmpAddr(input int ch);
    return ADDR_W'(16 + 12 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] liveAddr(input int ch);
    return (ch == NUM_CH - 1) ? ADDR_LIVE_LAST : ADDR_W'(20 + 12 * ch);
  endfunction
endpackage

// File: rtl/dtimer_chan.sv
`timescale 1ns/1ps
module dtimer_chan import dtimer_pkg::*; #(
  parameter int CNT_W = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  chanCmd_t         cmd,
  input  logic [CNT_W-1:0] wrVal,
  input  logic             tick,
  output logic [CNT_W-1:0] liveCnt,
  output logic [CNT_W-1:0] cntBuf,
  output logic [CNT_W-1:0] cmpBuf,
  output logic             expire,
  output logic             match
);
  logic [CNT_W-1:0] cntQ, cmpQ, cntBufQ, cmpBufQ;
  logic stepEn;

  assign stepEn = cmd.run && !cmd.manual && tick;
  assign expire = stepEn && (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      cmpQ    <= '0;
      cntBufQ <= '0;
      cmpBufQ <= '0;
    end else begin
      if (cmd.wrCnt) cntBufQ <= wrVal;
      if (HAS_CMP && cmd.wrCmp) cmpBufQ <= wrVal;
      if (cmd.manual) begin
        cntQ <= cntBufQ;
        cmpQ <= cmpBufQ;
      end else if (stepEn) begin
        if (cntQ == '0) begin
          if (cmd.autoReload) begin
            cntQ <= cntBufQ;
            cmpQ <= cmpBufQ;
          end
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  assign liveCnt = cntQ;
  assign cntBuf  = cntBufQ;
  assign cmpBuf  = cmpBufQ;
  assign match   = HAS_CMP && (cntQ == cmpQ);
endmodule

// File: rtl/dtimer_datapath.sv
`timescale 1ns/1ps
module dtimer_datapath import dtimer_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  chanCmd_t [NUM_CH-1:0]            cmd,
  input  logic [CNT_W-1:0]                 wrVal,
  input  logic [NUM_CH-1:0]                tickEn,
  output logic [NUM_CH-1:0][CNT_W-1:0]     liveCnt,
  output logic [NUM_CH-1:0][CNT_W-1:0]     cntBuf,
  output logic [NUM_CH-1:0][CNT_W-1:0]     cmpBuf,
  output logic [NUM_CH-1:0]                expireVec,
  output logic [NUM_CH-1:0]                matchVec
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    dtimer_chan #(
      .CNT_W  (CNT_W),
      .HAS_CMP(hasCmp(i))
    ) i_chan (
      .clk    (clk),
      .rstN   (rstN),
      .cmd    (cmd[i]),
      .wrVal  (wrVal),
      .tick   (tickEn[i]),
      .liveCnt(liveCnt[i]),
      .cntBuf (cntBuf[i]),
      .cmpBuf (cmpBuf[i]),
      .expire (expireVec[i]),
      .match  (matchVec[i])
    );
  end
endmodule

// File: rtl/dtimer_ctrl.sv
`timescale 1ns/1ps
module dtimer_ctrl import dtimer_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [NUM_CH-1:0]            expireVec,
  input  logic [NUM_CH-1:0][CNT_W-1:0] liveCnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cntBuf,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmpBuf,
  output chanCmd_t [NUM_CH-1:0]        cmd,
  output logic [NUM_CH-1:0]            intEn,
  output logic [NUM_CH-1:0]            intPend,
  output logic [DATA_W-1:0]            rdData,
  output logic                         irqOut
);
  localparam logic [DATA_W-1:0] CTRL_MASK = ctrlMask();

  logic [DATA_W-1:0] ctrlQ, ctrlNext;
  logic [NUM_CH-1:0] intEnQ, intPendQ, intEnNext, intPendNext, clrMask;
  logic wrCtrl, wrStat;

  assign wrCtrl = wrEn && (regAddr == ADDR_CTRL);
  assign wrStat = wrEn && (regAddr == ADDR_STAT);

  always_comb begin
    ctrlNext = wrCtrl ? (wrData & CTRL_MASK) : ctrlQ;
    for (int i = 0; i < NUM_CH; i++) begin
      if (expireVec[i] && !ctrlQ[ctrlBase(i) + BIT_AUTO])
        ctrlNext[ctrlBase(i) + BIT_RUN] = 1'b0;
    end
  end

  assign clrMask     = wrStat ? wrData[PEND_OFS +: NUM_CH] : '0;
  assign intEnNext   = wrStat ? wrData[NUM_CH-1:0] : intEnQ;
  assign intPendNext = (intPendQ & ~clrMask) | (expireVec & intEnQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      intEnQ   <= '0;
      intPendQ <= '0;
    end else begin
      ctrlQ    <= ctrlNext;
      intEnQ   <= intEnNext;
      intPendQ <= intPendNext;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmd
    assign cmd[i].run        = ctrlQ[ctrlBase(i) + BIT_RUN];
    assign cmd[i].manual     = ctrlQ[ctrlBase(i) + BIT_MAN];
    assign cmd[i].autoReload = ctrlQ[ctrlBase(i) + BIT_AUTO];
    assign cmd[i].wrCnt      = wrEn && (regAddr == cntAddr(i));
    assign cmd[i].wrCmp      = hasCmp(i) && wrEn && (regAddr == cmpAddr(i));
  end

  always_comb begin
    rdData = '0;
    if (regAddr == ADDR_CTRL) rdData = ctrlQ;
    if (regAddr == ADDR_STAT) rdData = DATA_W'({intPendQ, intEnQ});
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == cntAddr(i)) rdData = DATA_W'(cntBuf[i]);
      if (hasCmp(i) && regAddr == cmpAddr(i)) rdData = DATA_W'(cmpBuf[i]);
      if (regAddr == liveAddr(i)) rdData = DATA_W'(liveCnt[i]);
    end
  end

  assign intEn   = intEnQ;
  assign intPend = intPendQ;
  assign irqOut  = |(intEnQ & intPendQ);
endmodule

// File: rtl/dtimer_bank.sv
`timescale 1ns/1ps
module dtimer_bank import dtimer_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [4:0]        tickEn,
  output logic              irqOut
);
  chanCmd_t [NUM_CH-1:0]        cmd;
  logic [NUM_CH-1:0][CNT_W-1:0] liveCnt, cntBuf, cmpBuf;
  logic [NUM_CH-1:0]            expireVec, matchVec, intEn, intPend;
  logic [NUM_CH-1:0]            runVec, manVec, autoVec;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_view
    assign runVec[i]  = cmd[i].run;
    assign manVec[i]  = cmd[i].manual;
    assign autoVec[i] = cmd[i].autoReload;
  end

  dtimer_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .regAddr  (regAddr),
    .wrData   (wrData),
    .expireVec(expireVec),
    .liveCnt  (liveCnt),
    .cntBuf   (cntBuf),
    .cmpBuf   (cmpBuf),
    .cmd      (cmd),
    .intEn    (intEn),
    .intPend  (intPend),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );

  dtimer_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .wrVal    (wrData[CNT_W-1:0]),
    .tickEn   (tickEn),
    .liveCnt  (liveCnt),
    .cntBuf   (cntBuf),
    .cmpBuf   (cmpBuf),
    .expireVec(expireVec),
    .matchVec (matchVec)
  );
endmodule

// File: rtl/dtimer_bank_chk.sv
`timescale 1ns/1ps
module dtimer_bank_chk import dtimer_pkg::*; #(
  parameter int CNT_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CH-1:0]            tickEn,
  input logic                         irqOut,
  input logic [NUM_CH-1:0]            runVec,
  input logic [NUM_CH-1:0]            manVec,
  input logic [NUM_CH-1:0]            autoVec,
  input logic [NUM_CH-1:0]            expireVec,
  input logic [NUM_CH-1:0]            matchVec,
  input logic [NUM_CH-1:0]            intEn,
  input logic [NUM_CH-1:0]            intPend,
  input logic [NUM_CH-1:0][CNT_W-1:0] liveCnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] cntBuf,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmpBuf
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!irqOut && intEn == '0 && intPend == '0 && runVec == '0));

  a_r9_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == '0) |-> !irqOut);

  a_r8_pend_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((intPend & ~$past(intPend) & ~$past(intEn)) == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    a_r8_pend_sets: assert property (@(posedge clk) disable iff (!rstN)
      (expireVec[i] && intEn[i]) |=> intPend[i]);

    a_r4_manual_load: assert property (@(posedge clk) disable iff (!rstN)
      manVec[i] |=> (liveCnt[i] == $past(cntBuf[i])));

    a_r5_decrement: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[i] && !manVec[i] && tickEn[i] && liveCnt[i] != '0)
      |=> (liveCnt[i] == CNT_W'($past(liveCnt[i]) - 1'b1)));

    a_r5_frozen: assert property (@(posedge clk) disable iff (!rstN)
      (!runVec[i] && !manVec[i]) |=> $stable(liveCnt[i]));

    a_r6_reload: assert property (@(posedge clk) disable iff (!rstN)
      (expireVec[i] && autoVec[i]) |=> (liveCnt[i] == $past(cntBuf[i])));

    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
      (expireVec[i] && !autoVec[i]) |=> (!runVec[i] && liveCnt[i] == '0));

    if (hasCmp(i)) begin : g_cmp
      a_r4_match_after_load: assert property (@(posedge clk) disable iff (!rstN)
        manVec[i] |=> (matchVec[i] == ($past(cntBuf[i]) == $past(cmpBuf[i]))));
    end
  end
endmodule

bind dtimer_bank dtimer_bank_chk #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .irqOut   (irqOut),
  .runVec   (runVec),
  .manVec   (manVec),
  .autoVec  (autoVec),
  .expireVec(expireVec),
  .matchVec (matchVec),
  .intEn    (intEn),
  .intPend  (intPend),
  .liveCnt  (liveCnt),
  .cntBuf   (cntBuf),
  .cmpBuf   (cmpBuf)
);

// File: tb/test_dtimer_bank.sv
`timescale 1ns/1ps
module test_dtimer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [4:0]  tickEn = '0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  dtimer_bank i_dtimer_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .tickEn(tickEn), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] bufVal;
    logic [15:0] ticks;
    logic [31:0] expCnt;
    logic        expPend;
  } vec_t;

  // auto-reload runs: period is bufVal+1 ticks
  localparam vec_t VEC [7] = '{
    '{3'd0, 32'd5,  16'd3,  32'd2, 1'b0},
    '{3'd0, 32'd5,  16'd6,  32'd5, 1'b1},
    '{3'd1, 32'd3,  16'd9,  32'd2, 1'b1},
    '{3'd2, 32'd0,  16'd1,  32'd0, 1'b1},
    '{3'd3, 32'd10, 16'd10, 32'd0, 1'b0},
    '{3'd4, 32'd7,  16'd2,  32'd5, 1'b0},
    '{3'd4, 32'd2,  16'd4,  32'd1, 1'b1}
  };

  function automatic logic [7:0] aCnt(input int ch);
    return 8'(8'h0C + 12 * ch);
  endfunction
  function automatic logic [7:0] aLive(input int ch);
    return (ch == 4) ? 8'h40 : 8'(8'h14 + 12 * ch);
  endfunction
  function automatic logic [31:0] cBit(input int ch, input int b);
    return 32'(1) << (((ch == 0) ? 0 : 4 * (ch + 1)) + b);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic tick(input int ch, input int n);
    @(negedge clk);
    tickEn = 5'(1 << ch);
    repeat (n) @(negedge clk);
    tickEn = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h08, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h44, v); chk("R1 stat", v, 32'h0);
    for (int c = 0; c < 5; c++) begin
      rd(aLive(c), v); chk("R1 live", v, 32'h0);
      rd(aCnt(c), v);  chk("R1 cntbuf", v, 32'h0);
    end
    #1 chk("R1 irq", 32'(irqOut), 32'h0);

    // R2 control layout and unused bits
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R2 mask", v, 32'h00FF_FF0F);
    wr(8'h08, 32'h0);

    // R3 address map
    for (int c = 0; c < 4; c++) wr(8'(8'h10 + 12 * c), 32'h100 + 32'(c));
    for (int c = 0; c < 4; c++) begin
      rd(8'(8'h10 + 12 * c), v); chk("R3 cmpbuf", v, 32'h100 + 32'(c));
    end
    wr(8'h3C, 32'h55);
    rd(8'h3C, v); chk("R3 cntbuf4", v, 32'h55);
    wr(8'h40, 32'hABCD);
    rd(8'h40, v); chk("R3 live4 ro", v, 32'h0);
    wr(8'h14, 32'h77);
    rd(8'h14, v); chk("R3 live0 ro", v, 32'h0);

    // table: R2 positions, R6 reload, R8 pending, R9 irq
    foreach (VEC[k]) begin
      int ch;
      ch = int'(VEC[k].ch);
      wr(aCnt(ch), VEC[k].bufVal);
      wr(8'h08, cBit(ch, 1) | cBit(ch, 3));
      wr(8'h08, cBit(ch, 0) | cBit(ch, 3));
      wr(8'h44, 32'(1 << ch) | 32'h3E0);
      tick(ch, int'(VEC[k].ticks));
      rd(aLive(ch), v); chk("R6 live", v, VEC[k].expCnt);
      rd(8'h44, v); chk("R8 pend", 32'(v[ch + 5]), 32'(VEC[k].expPend));
      chk("R9 irq", 32'(irqOut), 32'(VEC[k].expPend));
    end
    wr(8'h44, 32'h3E0);

    // R4 manual load holds counter
    wr(8'h0C, 32'd20);
    wr(8'h08, 32'h3);
    tick(0, 5);
    rd(8'h14, v); chk("R4 hold", v, 32'd20);
    wr(8'h08, 32'h1);
    tick(0, 3);
    rd(8'h14, v); chk("R5 count", v, 32'd17);

    // R5 freeze while stopped, resume without reload
    wr(8'h08, 32'h0);
    tick(0, 4);
    rd(8'h14, v); chk("R5 freeze", v, 32'd17);
    wr(8'h08, 32'h1);
    tick(0, 2);
    rd(8'h14, v); chk("R5 resume", v, 32'd15);

    // R7 one-shot on channel 1
    wr(8'h08, 32'h0);
    wr(8'h18, 32'd2);
    wr(8'h44, 32'h3E0 | 32'h2);
    wr(8'h08, cBit(1, 1));
    wr(8'h08, cBit(1, 0));
    tick(1, 3);
    rd(8'h20, v); chk("R7 live zero", v, 32'd0);
    rd(8'h08, v); chk("R7 start cleared", v, 32'h0);
    rd(8'h44, v); chk("R7 pend", v, 32'h42);
    wr(8'h44, 32'h42);
    rd(8'h44, v); chk("R8 w1c", v, 32'h02);
    #1 chk("R9 irq low", 32'(irqOut), 32'h0);
    tick(1, 5);
    rd(8'h44, v); chk("R7 no re-expiry", v, 32'h02);
    rd(8'h20, v); chk("R7 stays zero", v, 32'd0);

    // R8 enable gating, R9 masking
    wr(8'h44, 32'h3E0);
    wr(8'h24, 32'd1);
    wr(8'h08, cBit(2, 1) | cBit(2, 3));
    wr(8'h08, cBit(2, 0) | cBit(2, 3));
    tick(2, 2);
    rd(8'h44, v); chk("R8 masked no pend", v, 32'h0);
    #1 chk("R9 irq masked", 32'(irqOut), 32'h0);
    wr(8'h44, 32'h4);
    tick(2, 2);
    rd(8'h44, v); chk("R8 pend set", v, 32'h84);
    #1 chk("R9 irq high", 32'(irqOut), 32'h1);
    wr(8'h44, 32'h0);
    rd(8'h44, v); chk("R9 pend kept", v, 32'h80);
    #1 chk("R9 irq dropped", 32'(irqOut), 32'h0);
    wr(8'h44, 32'h80);
    rd(8'h44, v); chk("R8 clear", v, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule